// File: doc/BRIEF.md
# Two-Stage Ping-Pong Statistics Readout Buffer

This block gathers a stream of 16-bit statistic words, such as per-tile brightness, colour and sharpness figures, and hands them to a host processor as small windows of 32-bit words. Incoming words fill one of two 128-entry pages. The page being filled can only take data while a free page is available; the other page is held until the host has consumed it. A transfer engine copies the held page, one 16-bit word per clock, into the hidden one of two 8-word windows. Each pair of 16-bit words becomes one 32-bit word, and the earlier word sits in the low half. The host reads the visible window and then pulses an advance strobe. That strobe exposes the other window and frees the first one for refilling.

Collection starts only at a frame boundary. Once the mode is enabled, the block waits for the next frame-start pulse before it accepts any word. A page is handed to the host when all 128 of its words are written, or when a frame ends with the page partly filled. In the second case an odd final word is padded with zero. The interrupt request rises on each hand-over. It falls once every buffered word has been read or skipped, or when the mode is switched off. Switching the mode off empties both stages.

The input is valid/ready. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low before collection is armed, while a frame-end flush is pending, and while both pages are waiting to be drained. While `in_ready` is low the producer must hold its word. The other pins are plain levels or single-cycle pulses.

Top module: `stat_pingpong_readout`

## Requirements
- R1: After `mode_en` rises, `in_ready` stays low until a `frame_start` pulse is seen. Words are accepted from the cycle after that pulse onward.
- R2: `in_ready` is low while both 128-word pages are full and waiting to be drained. It returns high once the oldest page has been fully advanced through.
- R3: Window word k (selected by `rd_addr`) holds 16-bit words 2k and 2k+1 of its segment, as {word 2k+1, word 2k}. The earlier word occupies bits 15:0.
- R4: When the 128th word of a page is accepted, `irq` rises within two cycles. The page is then shown as 8 successive windows of 8 words each, in arrival order, and each window reports `win_words` = 8.
- R5: `ready` is high exactly when the visible window holds data. An `adv` pulse while `ready` is low has no effect, and the next data lands in the same window position.
- R6: A `frame_end` pulse with 1 to 127 words in the filling page hands that page over. An odd count is padded with a zero upper half, and `win_words` shows the number of valid 32-bit words in the window.
- R7: `irq` falls within three cycles after the last buffered window is advanced. A `frame_end` with an empty page raises no `irq`.
- R8: Driving `mode_en` low clears `irq`, `ready` and `in_ready` within two cycles and discards all buffered data.
- R9: After a page is handed over, or after an advance while a full page is still held, the next window becomes ready within 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Collection mode enable; low empties the buffer |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_end | input | 1 | One-cycle pulse at the end of a frame |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Buffer accepts the word this cycle |
| in_data | input | 16 | Statistic word |
| adv | input | 1 | One-cycle pulse: release the visible window |
| rd_addr | input | 3 | Word index inside the visible window |
| rd_data | output | 32 | Selected packed word of the visible window |
| ready | output | 1 | Visible window holds valid data |
| win_words | output | 4 | Valid 32-bit words in the visible window (0 when not ready) |
| irq | output | 1 | Interrupt request: data handed over and not yet consumed |

## Verification
A wrong fill or drain pointer shows up at `rd_data` as swapped halves, shifted words or stale page contents, and it does so in the first window read after the hand-over. A lost or stuck page flag has two effects. It either holds `in_ready` low for good after two pages, or it makes the same page reappear after its eighth advance, and both effects become visible within one page of traffic. A wrong idle term leaves `irq` high after the final advance, or drops it while windows are still pending, and this is visible within three cycles.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic {XF_IDLE = 1'b0, XF_COPY = 1'b1} xfer_state_e;

  function automatic int unsigned half_ceil(input int unsigned n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/sbuf_ingest.sv
module sbuf_ingest #(
  parameter int DW = 16,
  parameter int PW = 128,
  localparam int PA = $clog2(PW),
  localparam int CW = $clog2(PW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [PA-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic          head_full,
  output logic [CW-1:0] head_cnt,
  input  logic          release_pg,
  output logic          commit,
  output logic          any_full
);
  logic [DW-1:0] mem [2][PW];
  logic [1:0]    full_q;
  logic [CW-1:0] cnt_q [2];
  logic          wpg_q, rpg_q;
  logic [PA-1:0] wptr_q;
  logic          synced_q, end_pend_q;
  logic          accept;

  assign in_ready  = en && synced_q && !end_pend_q && !full_q[wpg_q];
  assign accept    = in_valid && in_ready;
  assign rd_word   = mem[rpg_q][rd_idx];
  assign head_full = full_q[rpg_q];
  assign head_cnt  = cnt_q[rpg_q];
  assign any_full  = |full_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wpg_q][wptr_q] <= in_data;
    end else if (en && end_pend_q && wptr_q[0]) begin
      mem[wpg_q][wptr_q] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0; cnt_q[0] <= '0; cnt_q[1] <= '0;
      wpg_q <= 1'b0; rpg_q <= 1'b0; wptr_q <= '0;
      synced_q <= 1'b0; end_pend_q <= 1'b0; commit <= 1'b0;
    end else if (!en) begin
      full_q <= '0; cnt_q[0] <= '0; cnt_q[1] <= '0;
      wpg_q <= 1'b0; rpg_q <= 1'b0; wptr_q <= '0;
      synced_q <= 1'b0; end_pend_q <= 1'b0; commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (frame_start) synced_q <= 1'b1;
      if (accept) begin
        if (wptr_q == PA'(PW - 1)) begin
          full_q[wpg_q] <= 1'b1;
          cnt_q[wpg_q]  <= CW'(PW);
          wpg_q         <= ~wpg_q;
          wptr_q        <= '0;
          commit        <= 1'b1;
        end else begin
          wptr_q <= wptr_q + 1'b1;
        end
      end else if (end_pend_q) begin
        end_pend_q <= 1'b0;
        if (wptr_q != '0) begin
          full_q[wpg_q] <= 1'b1;
          cnt_q[wpg_q]  <= CW'(wptr_q) + CW'(wptr_q[0]);
          wpg_q         <= ~wpg_q;
          wptr_q        <= '0;
          commit        <= 1'b1;
        end
      end
      if (frame_end && synced_q) end_pend_q <= 1'b1;
      if (release_pg) begin
        full_q[rpg_q] <= 1'b0;
        rpg_q         <= ~rpg_q;
      end
    end
  end

  AST_PAGE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cnt_q[~wpg_q][0] == 1'b0)) else $error("odd page count"); // R6
endmodule

// File: rtl/sbuf_window.sv
module sbuf_window
  import sbuf_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 128,
  parameter int WN = 8,
  localparam int PA = $clog2(PW),
  localparam int CW = $clog2(PW + 1),
  localparam int SW = 2 * WN,
  localparam int SA = $clog2(SW),
  localparam int WA = $clog2(WN),
  localparam int WC = $clog2(WN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            head_full,
  input  logic [CW-1:0]   head_cnt,
  output logic [PA-1:0]   rd_idx,
  input  logic [DW-1:0]   rd_word,
  output logic            release_pg,
  input  logic            adv,
  input  logic [WA-1:0]   rd_addr,
  output logic [2*DW-1:0] rd_data,
  output logic            ready,
  output logic [WC-1:0]   win_words,
  output logic            busy,
  output logic            any_valid
);
  logic [DW-1:0] slot [2][SW];
  logic [1:0]    valid_q;
  logic [WC-1:0] words_q [2];
  logic          cur_q, fsl_q;
  xfer_state_e   st_q;
  logic [SA-1:0] j_q;
  logic [CW:0]   sptr_q;
  logic [CW:0]   idx, rem, seg, nxt;
  logic [DW-1:0] wdat;
  logic          last_step;

  assign busy      = (st_q == XF_COPY);
  assign idx       = sptr_q + (CW+1)'(j_q);
  assign rd_idx    = idx[PA-1:0];
  assign wdat      = (idx < (CW+1)'(head_cnt)) ? rd_word : '0;
  assign rem       = (CW+1)'(head_cnt) - sptr_q;
  assign seg       = (rem > (CW+1)'(SW)) ? (CW+1)'(SW) : rem;
  assign nxt       = sptr_q + (CW+1)'(SW);
  assign last_step = busy && (j_q == SA'(SW - 1));
  assign release_pg = last_step && (nxt >= (CW+1)'(head_cnt));
  assign ready     = valid_q[cur_q];
  assign win_words = ready ? words_q[cur_q] : '0;
  assign any_valid = |valid_q;

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      assign rd_data[h*DW +: DW] = slot[cur_q][{rd_addr, 1'(h)}];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (busy) slot[fsl_q][j_q] <= wdat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0; words_q[0] <= '0; words_q[1] <= '0;
      cur_q <= 1'b0; fsl_q <= 1'b0; st_q <= XF_IDLE; j_q <= '0; sptr_q <= '0;
    end else if (!en) begin
      valid_q <= '0; words_q[0] <= '0; words_q[1] <= '0;
      cur_q <= 1'b0; fsl_q <= 1'b0; st_q <= XF_IDLE; j_q <= '0; sptr_q <= '0;
    end else begin
      if (!busy && !valid_q[fsl_q] && head_full) begin
        st_q <= XF_COPY;
        j_q  <= '0;
      end
      if (busy) begin
        j_q <= j_q + 1'b1;
        if (last_step) begin
          st_q            <= XF_IDLE;
          valid_q[fsl_q]  <= 1'b1;
          words_q[fsl_q]  <= WC'(seg >> 1);
          fsl_q           <= ~fsl_q;
          sptr_q          <= release_pg ? '0 : nxt;
        end
      end
      if (adv && valid_q[cur_q]) begin
        valid_q[cur_q] <= 1'b0;
        cur_q          <= ~cur_q;
      end
    end
  end

  AST_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && !ready) |=> $stable(cur_q)) else $error("adv moved empty window"); // R5
  AST_COPY_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> head_full) else $error("copy from empty page"); // R4
endmodule

// File: rtl/stat_pingpong_readout.sv
module stat_pingpong_readout #(
  parameter int DW = 16,
  parameter int PW = 128,
  parameter int WN = 8,
  localparam int PA = $clog2(PW),
  localparam int CW = $clog2(PW + 1),
  localparam int WA = $clog2(WN),
  localparam int WC = $clog2(WN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_en,
  input  logic            frame_start,
  input  logic            frame_end,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic            adv,
  input  logic [WA-1:0]   rd_addr,
  output logic [2*DW-1:0] rd_data,
  output logic            ready,
  output logic [WC-1:0]   win_words,
  output logic            irq
);
  logic [PA-1:0] rd_idx;
  logic [DW-1:0] rd_word;
  logic          head_full, release_pg, commit, any_full, busy, any_valid;
  logic [CW-1:0] head_cnt;
  logic          idle;

  sbuf_ingest #(.DW(DW), .PW(PW)) ingest_i (
    .clk(clk), .rst_n(rst_n), .en(mode_en),
    .frame_start(frame_start), .frame_end(frame_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .head_full(head_full), .head_cnt(head_cnt),
    .release_pg(release_pg), .commit(commit), .any_full(any_full)
  );

  sbuf_window #(.DW(DW), .PW(PW), .WN(WN)) window_i (
    .clk(clk), .rst_n(rst_n), .en(mode_en),
    .head_full(head_full), .head_cnt(head_cnt),
    .rd_idx(rd_idx), .rd_word(rd_word), .release_pg(release_pg),
    .adv(adv), .rd_addr(rd_addr), .rd_data(rd_data),
    .ready(ready), .win_words(win_words), .busy(busy), .any_valid(any_valid)
  );

  assign idle = !any_full && !any_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (!mode_en) irq <= 1'b0;
    else if (commit)  irq <= 1'b1;
    else if (idle)    irq <= 1'b0;
  end

  AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !irq) else $error("irq while disabled"); // R8
  AST_IRQ_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(commit)) else $error("irq without hand-over"); // R4
endmodule

// File: tb/stat_pingpong_readout_tb_top.sv
module stat_pingpong_readout_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
  logic        in_valid = 1'b0, adv = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  rd_addr = '0;
  logic        in_ready, ready, irq;
  logic [31:0] rd_data;
  logic [3:0]  win_words;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  stat_pingpong_readout dut_i (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .frame_start(frame_start), .frame_end(frame_end),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .adv(adv), .rd_addr(rd_addr), .rd_data(rd_data),
    .ready(ready), .win_words(win_words), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fs(); frame_start = 1'b1; cyc(1); frame_start = 1'b0; endtask
  task automatic pulse_fe(); frame_end = 1'b1; cyc(1); frame_end = 1'b0; endtask
  task automatic pulse_adv(); adv = 1'b1; cyc(1); adv = 1'b0; endtask

  task automatic push(input logic [15:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) cyc(1);
    cyc(1);
    in_valid = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !ready; i++) cyc(1);
  endtask

  task automatic read_word(input int k, output logic [31:0] v);
    rd_addr = 3'(k); #1; v = rd_data;
  endtask

  task automatic t_reset();
    chk(!ready && !irq && !in_ready, "R8 reset state", {29'b0, ready, irq, in_ready}, 32'h0);
  endtask

  task automatic t_arm();
    mode_en = 1'b1; cyc(3);
    chk(!in_ready, "R1 not armed before frame start", {31'b0, in_ready}, 32'h0);
    pulse_fs();
    chk(in_ready, "R1 armed after frame start", {31'b0, in_ready}, 32'h1);
  endtask

  task automatic t_full_page();
    logic [31:0] v;
    for (int i = 0; i < 128; i++) push(16'h1000 + 16'(i));
    cyc(1);
    chk(irq, "R4 irq after full page", {31'b0, irq}, 32'h1);
    cyc(19);
    chk(ready, "R9 first window ready", {31'b0, ready}, 32'h1);
    for (int w = 0; w < 8; w++) begin
      wait_ready(20);
      chk(ready, "R9 window ready after advance", {31'b0, ready}, 32'h1);
      chk(win_words == 4'd8, "R4 window word count", {28'b0, win_words}, 32'd8);
      for (int k = 0; k < 8; k += 3) begin
        read_word(k, v);
        chk(v == {16'h1000 + 16'(16*w + 2*k + 1), 16'h1000 + 16'(16*w + 2*k)},
            "R3 packed word low first", v,
            {16'h1000 + 16'(16*w + 2*k + 1), 16'h1000 + 16'(16*w + 2*k)});
      end
      pulse_adv();
    end
    cyc(3);
    chk(!irq && !ready, "R7 irq clears after last window", {30'b0, irq, ready}, 32'h0);
  endtask

  task automatic t_partial();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) push(16'hA000 + 16'(i));
    pulse_fe();
    wait_ready(25);
    chk(irq, "R6 irq after partial frame", {31'b0, irq}, 32'h1);
    chk(win_words == 4'd3, "R6 valid word count", {28'b0, win_words}, 32'd3);
    read_word(1, v);
    chk(v == 32'hA003_A002, "R6 middle word", v, 32'hA003_A002);
    read_word(2, v);
    chk(v == 32'h0000_A004, "R6 zero padded word", v, 32'h0000_A004);
    pulse_adv(); cyc(3);
    chk(!irq, "R7 irq clears after partial read", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_empty_end();
    pulse_fe(); cyc(5);
    chk(!irq && !ready, "R7 empty frame end no irq", {30'b0, irq, ready}, 32'h0);
  endtask

  task automatic t_adv_ignored();
    logic [31:0] v;
    pulse_adv(); pulse_adv();
    push(16'hB000); push(16'hB001); pulse_fe();
    wait_ready(25);
    read_word(0, v);
    chk(v == 32'hB001_B000, "R5 ignored advance keeps order", v, 32'hB001_B000);
    chk(win_words == 4'd1, "R5 single word window", {28'b0, win_words}, 32'd1);
    pulse_adv(); cyc(3);
    chk(!ready, "R5 ready low when window empty", {31'b0, ready}, 32'h0);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    for (int i = 0; i < 256; i++) push(16'h2000 + 16'(i));
    in_valid = 1'b1; in_data = 16'hFFFF; cyc(2);
    chk(!in_ready, "R2 stalled with both pages held", {31'b0, in_ready}, 32'h0);
    for (int w = 0; w < 8; w++) begin wait_ready(20); pulse_adv(); end
    cyc(2);
    chk(in_ready, "R2 resumes after page drained", {31'b0, in_ready}, 32'h1);
    in_valid = 1'b0;
    wait_ready(20);
    read_word(0, v);
    chk(v == 32'h2081_2080, "R2 second page follows", v, 32'h2081_2080);
  endtask

  task automatic t_disable();
    mode_en = 1'b0; cyc(2);
    chk(!irq && !ready && !in_ready, "R8 disable clears", {29'b0, irq, ready, in_ready}, 32'h0);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset();
    t_arm();
    t_full_page();
    t_partial();
    t_empty_end();
    t_adv_ignored();
    t_backpressure();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule